// File: doc/BRIEF.md
# Buffered 16-bit timer/counter

A 16-bit up-counter that software reaches through an 8-bit register bus. It advances either on a fixed internal instruction tick (the system clock divided by `INSTR_DIV`) or on rising edges of an external clock input. The external input can pass through a two-flop synchronizer before edge detection, or it can be edge-detected directly for the shortest latency. A prescaler sits between the selected source and the counter.

An 8-bit bus cannot move a 16-bit value in one access, so a buffered access mode ties the high byte to low-byte accesses. A low-byte read takes a snapshot of the high byte. A high-byte write is held until the next low-byte write. Both halves therefore always come from, or land in, the same clock cycle. A rollover from all ones to zero sets a sticky overflow flag. An external trigger input forces the count to zero.

Register map (`bus_addr`): 0 = control, 1 = count low byte, 2 = count high byte, 3 = unused (reads 0). Control bits: 0 run, 1 external source select, 2 unsynchronized external path, 4:3 prescale select, 6 buffered 16-bit access, 7 overflow flag.

Top module: `tmr16_unit`

## Requirements
- R1: After reset the control register, both count bytes and `ovf_flag` read 0.
- R2: With control bit 1 = 0 and run set, the count rises by one every `INSTR_DIV` × prescale system clock cycles.
- R3: With control bit 1 = 1 and run set, the count rises once per rising edge of `ext_clk_in`, divided by the prescale ratio.
- R4: Control bits 4:3 select a prescale ratio: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8.
- R5: With control bit 2 = 0, an external rising edge reaches the count on the third rising clock edge after the input rises. With bit 2 = 1 it reaches the count on the first edge.
- R6: While control bit 0 (run) is 0 the count does not change, whatever the source does.
- R7: A count wrap from 0xFFFF to 0x0000 sets `ovf_flag` and control bit 7. The flag stays set until a control write carries bit 7 = 0. A control write with bit 7 = 1 leaves the flag unchanged.
- R8: `evt_clear` high at a clock edge makes the count 0 after that edge. It takes priority over a bus write to the count in the same cycle.
- R9: With control bit 6 = 1, a low-byte read (`bus_rd` at address 1) copies the live high byte into a buffer. High-byte reads then return that buffer.
- R10: With control bit 6 = 1, a high-byte write changes only the buffer. The next low-byte write loads the buffer and the written low byte into the count together.
- R11: With control bit 6 = 0, the high and low bytes are read and written directly.
- R12: Any bus write to the control register or to either count byte restarts the prescaler's internal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect for buffered reads) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| ext_clk_in | input | 1 | External count input |
| evt_clear | input | 1 | Special-event trigger, clears the count |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its default values: an 8-bit bus and an instruction divider of 4. With these values, a 64-cycle observation window yields a whole number of counts at every prescale ratio, so each ratio is checked exactly against the free-running timer. Rollover is reached by preloading 0xFFFE rather than by counting 65,536 events. The synchronizer's extra two cycles are measured directly against the unsynchronized path on the same input edge.

// File: rtl/tmr16_pkg.sv
// Shared definitions for the buffered 16-bit timer/counter.
// Assumes a bus of at least 8 bits; control bit positions are fixed.
package tmr16_pkg;

    localparam int PS_W = 2;

    typedef enum logic [1:0] {
        ADR_CTRL = 2'd0,
        ADR_LO   = 2'd1,
        ADR_HI   = 2'd2,
        ADR_NONE = 2'd3
    } adr_e;

    localparam int B_RUN   = 0;
    localparam int B_EXT   = 1;
    localparam int B_ASYNC = 2;
    localparam int B_PS_LO = 3;
    localparam int B_WIDE  = 6;
    localparam int B_FLAG  = 7;

    typedef struct packed {
        logic            wide;
        logic [PS_W-1:0] ps;
        logic            async_en;
        logic            ext_sel;
        logic            run;
    } ctrl_t;

endpackage

// File: rtl/tmr16_tick_src.sv
// Count source selection. It produces a one-cycle tick from either the
// internal instruction divider or the external input. The external input
// goes through a two-flop synchronizer plus edge detector, or, on the
// unsynchronized path, through a single-flop edge detector.
// Assumes: external pulses are at least one system clock high and low.
module tmr16_tick_src #(
    parameter int INSTR_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic ext_sel,
    input  logic async_en,
    output logic tick
);
    logic instr_tick;
    logic s_meta, s_stab, s_prev, a_prev;
    logic edge_sync, edge_async;

    generate
        if (INSTR_DIV > 1) begin : g_div
            localparam int DW = $clog2(INSTR_DIV);
            logic [DW-1:0] div_q;
            assign instr_tick = (div_q == DW'(INSTR_DIV - 1));
            // Free-running instruction-cycle divider.
            always_ff @(posedge clk) begin
                if (!rst_n)          div_q <= '0;
                else if (instr_tick) div_q <= '0;
                else                 div_q <= div_q + 1'b1;
            end
        end else begin : g_nodiv
            assign instr_tick = 1'b1;
        end
    endgenerate

    // Two-flop synchronizer plus edge-history flops for both external paths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_meta <= 1'b0;
            s_stab <= 1'b0;
            s_prev <= 1'b0;
            a_prev <= 1'b0;
        end else begin
            s_meta <= ext_in;
            s_stab <= s_meta;
            s_prev <= s_stab;
            a_prev <= ext_in;
        end
    end

    assign edge_sync  = s_stab & ~s_prev;
    assign edge_async = ext_in & ~a_prev;

    // Select the active source.
    always_comb begin
        if (!ext_sel)      tick = instr_tick;
        else if (async_en) tick = edge_async;
        else               tick = edge_sync;
    end
endmodule

// File: rtl/tmr16_prescale.sv
// Prescaler: passes one of every 2**ps enabled ticks. A clear restarts the
// internal count and suppresses any pulse in the same cycle.
// Assumes: ticks are single-cycle pulses.
module tmr16_prescale #(
    parameter int PS_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            clr,
    input  logic [PS_W-1:0] ps,
    input  logic            tick,
    output logic            pulse
);
    localparam int CW = (1 << PS_W) - 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] mask;
    logic          hit;

    // Terminal-count mask: low ps bits set.
    always_comb begin
        mask = '0;
        for (int i = 0; i < CW; i++) begin
            if (i < int'(ps)) mask[i] = 1'b1;
        end
    end

    assign hit   = tick & en & ~clr;
    assign pulse = hit & ((cnt_q & mask) == mask);

    // Division counter, restarted by clr or after each output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (hit) cnt_q <= pulse ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/tmr16_core.sv
// Register core: control register, the 2*BUS_W count, the high-byte buffer
// for atomic access and the sticky overflow flag. Priority on the count:
// special-event clear, then bus write, then increment.
// Assumes BUS_W >= 8 so that every control bit has a home.
module tmr16_core #(
    parameter int BUS_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [1:0]                    bus_addr,
    input  logic [BUS_W-1:0]              bus_wdata,
    input  logic                          evt_clear,
    input  logic                          inc,
    output logic [BUS_W-1:0]              bus_rdata,
    output logic [2*BUS_W-1:0]            cnt_q,
    output logic                          ovf_q,
    output tmr16_pkg::ctrl_t              ctrl_q
);
    import tmr16_pkg::*;

    localparam int CNT_W = 2 * BUS_W;

    logic [BUS_W-1:0] hi_buf_q;
    logic wr_ctrl, wr_lo, wr_hi, rd_lo;
    logic cnt_written, wrap;

    assign wr_ctrl = bus_wr && (bus_addr == ADR_CTRL);
    assign wr_lo   = bus_wr && (bus_addr == ADR_LO);
    assign wr_hi   = bus_wr && (bus_addr == ADR_HI);
    assign rd_lo   = bus_rd && (bus_addr == ADR_LO);

    assign cnt_written = wr_lo || (wr_hi && !ctrl_q.wide);
    assign wrap        = inc && !evt_clear && !cnt_written && (cnt_q == '1);

    // Control register fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.run      <= bus_wdata[B_RUN];
            ctrl_q.ext_sel  <= bus_wdata[B_EXT];
            ctrl_q.async_en <= bus_wdata[B_ASYNC];
            ctrl_q.ps       <= bus_wdata[B_PS_LO +: PS_W];
            ctrl_q.wide     <= bus_wdata[B_WIDE];
        end
    end

    // Main count with clear, write and increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (evt_clear)
            cnt_q <= '0;
        else if (wr_lo)
            cnt_q <= ctrl_q.wide ? {hi_buf_q, bus_wdata} : {cnt_q[CNT_W-1:BUS_W], bus_wdata};
        else if (wr_hi && !ctrl_q.wide)
            cnt_q <= {bus_wdata, cnt_q[BUS_W-1:0]};
        else if (inc)
            cnt_q <= cnt_q + 1'b1;
    end

    // High-byte buffer shared by buffered reads and writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                      hi_buf_q <= '0;
        else if (wr_hi && ctrl_q.wide)   hi_buf_q <= bus_wdata;
        else if (rd_lo && ctrl_q.wide)   hi_buf_q <= cnt_q[CNT_W-1:BUS_W];
    end

    // Sticky overflow flag: set on wrap, cleared by control write with bit 7 low.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ovf_q <= 1'b0;
        else if (wrap)                       ovf_q <= 1'b1;
        else if (wr_ctrl && !bus_wdata[B_FLAG]) ovf_q <= 1'b0;
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_CTRL: begin
                bus_rdata[B_RUN]            = ctrl_q.run;
                bus_rdata[B_EXT]            = ctrl_q.ext_sel;
                bus_rdata[B_ASYNC]          = ctrl_q.async_en;
                bus_rdata[B_PS_LO +: PS_W]  = ctrl_q.ps;
                bus_rdata[B_WIDE]           = ctrl_q.wide;
                bus_rdata[B_FLAG]           = ovf_q;
            end
            ADR_LO:   bus_rdata = cnt_q[BUS_W-1:0];
            ADR_HI:   bus_rdata = ctrl_q.wide ? hi_buf_q : cnt_q[CNT_W-1:BUS_W];
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr16_unit.sv
// Top of the buffered timer/counter: source select, prescaler and register
// core. Any bus write to a defined register restarts the prescaler.
// Assumes all inputs except ext_clk_in are synchronous to clk.
module tmr16_unit #(
    parameter int BUS_W     = 8,
    parameter int INSTR_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             ext_clk_in,
    input  logic             evt_clear,
    output logic             ovf_flag
);
    import tmr16_pkg::*;

    localparam int CNT_W = 2 * BUS_W;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             run_q, wide_q;
    logic             src_tick, inc_pulse, psc_clr;

    assign run_q    = ctrl_q.run;
    assign wide_q   = ctrl_q.wide;
    assign psc_clr  = bus_wr && (bus_addr != ADR_NONE);
    assign ovf_flag = ovf_q;

    tmr16_tick_src #(.INSTR_DIV(INSTR_DIV)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_in   (ext_clk_in),
        .ext_sel  (ctrl_q.ext_sel),
        .async_en (ctrl_q.async_en),
        .tick     (src_tick)
    );

    tmr16_prescale #(.PS_W(PS_W)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run_q),
        .clr   (psc_clr),
        .ps    (ctrl_q.ps),
        .tick  (src_tick),
        .pulse (inc_pulse)
    );

    tmr16_core #(.BUS_W(BUS_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .evt_clear (evt_clear),
        .inc       (inc_pulse),
        .bus_rdata (bus_rdata),
        .cnt_q     (cnt_q),
        .ovf_q     (ovf_q),
        .ctrl_q    (ctrl_q)
    );
endmodule

// File: rtl/tmr16_chk.sv
// Property checker for tmr16_unit, attached by bind below.
// Assumes synchronous active-low reset held from time zero.
module tmr16_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             evt_clear,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [CNT_W-1:0] cnt_q,
    input logic             run_q,
    input logic             wide_q,
    input logic             ovf_q,
    input logic             inc_pulse
);
    a_r8_evt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        evt_clear |=> (cnt_q == '0));

    a_r6_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !evt_clear && !bus_wr) |=> $stable(cnt_q));

    a_r6_no_inc_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !inc_pulse);

    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_clear && !bus_wr) |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)));

    a_r7_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_q == '1) && inc_pulse && !evt_clear && !bus_wr) |=> ovf_q);

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(bus_wr && bus_addr == 2'd0)) |=> ovf_q);

    a_r10_hi_buffered: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_q && !run_q && bus_wr && bus_addr == 2'd2 && !evt_clear) |=> $stable(cnt_q));
endmodule

bind tmr16_unit tmr16_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_clear (evt_clear),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .cnt_q     (cnt_q),
    .run_q     (run_q),
    .wide_q    (wide_q),
    .ovf_q     (ovf_q),
    .inc_pulse (inc_pulse)
);

// File: tb/sim_tmr16_unit.sv
// Directed bench for tmr16_unit: one task per scenario, each checking itself.
module sim_tmr16_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       ext_clk_in = 1'b0;
    logic       evt_clear = 1'b0;
    logic       ovf_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr16_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_clk_in(ext_clk_in), .evt_clear(evt_clear), .ovf_flag(ovf_flag)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Control byte: bit0 run, 1 ext, 2 async, 4:3 ps, 6 wide, 7 keep flag.
    function automatic logic [7:0] cb(bit run, bit ext, bit asy, int ps, bit wide, bit keep);
        return {keep, wide, 1'b0, 2'(ps), asy, ext, run};
    endfunction

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ext_pulse();
        @(negedge clk); ext_clk_in = 1'b1;
        repeat (2) @(negedge clk);
        ext_clk_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        peek(2'd0, v); check("R1 ctrl", {8'h0, v}, 16'h0);
        peek(2'd1, v); check("R1 lo", {8'h0, v}, 16'h0);
        peek(2'd2, v); check("R1 hi", {8'h0, v}, 16'h0);
        check("R1 flag", {15'h0, ovf_flag}, 16'h0);
    endtask

    task automatic t_direct();
        logic [7:0] v;
        wr(2'd1, 8'h34); wr(2'd2, 8'h12);
        @(negedge clk);
        peek(2'd1, v); check("R11 lo", {8'h0, v}, 16'h34);
        peek(2'd2, v); check("R11 hi", {8'h0, v}, 16'h12);
    endtask

    task automatic t_buf_write();
        logic [7:0] v;
        wr(2'd0, cb(0, 0, 0, 0, 1, 1));
        wr(2'd2, 8'h56);
        wr(2'd0, cb(0, 0, 0, 0, 0, 1));
        @(negedge clk);
        peek(2'd2, v); check("R10 hi unchanged", {8'h0, v}, 16'h12);
        wr(2'd0, cb(0, 0, 0, 0, 1, 1));
        wr(2'd1, 8'h78);
        wr(2'd0, cb(0, 0, 0, 0, 0, 1));
        @(negedge clk);
        peek(2'd2, v); check("R10 hi loaded", {8'h0, v}, 16'h56);
        peek(2'd1, v); check("R10 lo loaded", {8'h0, v}, 16'h78);
    endtask

    task automatic t_buf_read();
        logic [7:0] v;
        wr(2'd1, 8'hFF); wr(2'd2, 8'h00);
        wr(2'd0, cb(1, 1, 0, 0, 1, 1));
        rd(2'd1, v); check("R9 lo snapshot", {8'h0, v}, 16'hFF);
        ext_pulse();
        repeat (2) @(negedge clk);
        peek(2'd2, v); check("R9 hi from buffer", {8'h0, v}, 16'h00);
        rd(2'd1, v); check("R9 lo after carry", {8'h0, v}, 16'h00);
        @(negedge clk);
        peek(2'd2, v); check("R9 hi new snapshot", {8'h0, v}, 16'h01);
    endtask

    task automatic t_timer();
        logic [7:0] v0, v1;
        for (int ps = 0; ps < 4; ps++) begin
            wr(2'd0, cb(1, 0, 0, ps, 0, 1));
            repeat (10) @(negedge clk);
            peek(2'd1, v0);
            repeat (64) @(negedge clk);
            peek(2'd1, v1);
            check("R2 R4 timer rate", {8'h0, 8'(v1 - v0)}, 16'(64 / (4 << ps)));
        end
    endtask

    task automatic t_run_off();
        logic [7:0] v0, v1;
        wr(2'd0, cb(0, 0, 0, 0, 0, 1));
        @(negedge clk); peek(2'd1, v0);
        repeat (40) @(negedge clk);
        peek(2'd1, v1);
        check("R6 timer stopped", {8'h0, v1}, {8'h0, v0});
        wr(2'd0, cb(0, 1, 1, 0, 0, 1));
        ext_pulse(); ext_pulse();
        peek(2'd1, v1);
        check("R6 ext stopped", {8'h0, v1}, {8'h0, v0});
    endtask

    task automatic t_ext_prescale();
        logic [7:0] v0, v1;
        wr(2'd0, cb(1, 1, 0, 2, 0, 1));
        repeat (3) @(negedge clk); peek(2'd1, v0);
        for (int i = 0; i < 12; i++) ext_pulse();
        peek(2'd1, v1);
        check("R3 R4 ext divide 4", {8'h0, 8'(v1 - v0)}, 16'd3);
    endtask

    task automatic t_latency(bit asy);
        logic [7:0] v0, v;
        wr(2'd0, cb(1, 1, asy, 0, 0, 1));
        repeat (4) @(negedge clk); peek(2'd1, v0);
        ext_clk_in = 1'b1;
        @(negedge clk); peek(2'd1, v);
        check(asy ? "R5 async first edge" : "R5 sync first edge",
              {8'h0, 8'(v - v0)}, asy ? 16'd1 : 16'd0);
        repeat (2) @(negedge clk); peek(2'd1, v);
        check("R5 third edge", {8'h0, 8'(v - v0)}, 16'd1);
        ext_clk_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_overflow();
        logic [7:0] v;
        wr(2'd0, cb(0, 0, 0, 0, 0, 1));
        wr(2'd1, 8'hFE); wr(2'd2, 8'hFF);
        wr(2'd0, cb(1, 1, 1, 0, 0, 1));
        ext_pulse();
        check("R7 no flag at FFFF", {15'h0, ovf_flag}, 16'h0);
        ext_pulse();
        peek(2'd2, v); check("R7 wrapped hi", {8'h0, v}, 16'h00);
        check("R7 flag set", {15'h0, ovf_flag}, 16'h1);
        repeat (10) @(negedge clk);
        peek(2'd0, v); check("R7 ctrl bit7", {15'h0, v[7]}, 16'h1);
        wr(2'd0, cb(0, 1, 1, 0, 0, 1));
        check("R7 keep on bit7=1", {15'h0, ovf_flag}, 16'h1);
        wr(2'd0, cb(0, 1, 1, 0, 0, 0));
        check("R7 cleared", {15'h0, ovf_flag}, 16'h0);
    endtask

    task automatic t_evt();
        logic [7:0] v;
        wr(2'd1, 8'h21); wr(2'd2, 8'h43);
        @(negedge clk); evt_clear = 1'b1;
        @(negedge clk); evt_clear = 1'b0;
        peek(2'd1, v); check("R8 lo zero", {8'h0, v}, 16'h0);
        peek(2'd2, v); check("R8 hi zero", {8'h0, v}, 16'h0);
        @(negedge clk);
        bus_addr = 2'd1; bus_wdata = 8'h55; bus_wr = 1'b1; evt_clear = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; evt_clear = 1'b0;
        peek(2'd1, v); check("R8 beats write", {8'h0, v}, 16'h0);
    endtask

    task automatic t_psc_clear();
        logic [7:0] v0, v;
        wr(2'd0, cb(1, 1, 0, 3, 0, 1));
        repeat (3) @(negedge clk); peek(2'd1, v0);
        for (int i = 0; i < 5; i++) ext_pulse();
        wr(2'd0, cb(1, 1, 0, 3, 0, 1));
        for (int i = 0; i < 7; i++) ext_pulse();
        peek(2'd1, v); check("R12 restarted", {8'h0, 8'(v - v0)}, 16'd0);
        ext_pulse();
        peek(2'd1, v); check("R12 eighth after write", {8'h0, 8'(v - v0)}, 16'd1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direct();
        t_buf_write();
        t_buf_read();
        t_timer();
        t_run_off();
        t_ext_prescale();
        t_latency(1'b0);
        t_latency(1'b1);
        t_overflow();
        t_evt();
        t_psc_clear();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule